// File: doc/BRIEF.md
# Bus-mapped push-button and LED target

This block sits on a simple asynchronous eight-bit initiator/target bus that uses an active-low request and an active-low acknowledge, and it exposes two bus addresses. A read of the button address returns the state of a push-button on the least significant data line. A write to the LED address stores one data bit into a register whose output drives an LED. The target runs on its own local clock. It passes the incoming request strobe and the button through flop synchronizers. It samples the command, address and write data only after the synchronized request is seen low, because the initiator holds them stable from before it lowers the request.

The target answers only the two transactions it owns. For any other address, or for the wrong direction at one of its two addresses, it neither drives the data bus nor acknowledges, so another target on the bus can answer. The data bus is shown as a separate output value plus an output enable, which an outer pad or tri-state stage turns into the shared lines. When the initiator raises the request at the end of a transaction, the target first releases the data bus and then raises the acknowledge on the next cycle.

Top module: `mmio_button_led_target`

## Requirements
- R1: When the synchronized request is low, the command line is 0 (read) and the address equals BTN_ADDR (default 0x04), the target drives data_out with the synchronized button on bit 0 and zeros on bits 7:1, and asserts data_oe.
- R2: When the synchronized request is low, the command line is 1 (write) and the address equals LED_ADDR (default 0x05), the LED register takes data_in bit 0. Bits 7:1 of data_in have no effect.
- R3: For an owned transaction, ack_n goes low ACK_DELAY clock edges after the edge on which the read data is driven or the write data is stored. That edge is the first edge at which the two-stage synchronized request reads low, so ack_n falls 3+ACK_DELAY edges after req_n falls.
- R4: Once the synchronized request reads high while ack_n is low, data_oe drops on that edge, and ack_n returns high on the following edge.
- R5: Any transaction that is not owned (a read of LED_ADDR, a write of BTN_ADDR, or any other address) produces no acknowledge and no data drive, and it leaves the LED unchanged.
- R6: While reset is held, and right after it, ack_n is 1, data_oe is 0 and the LED is 0.
- R7: data_oe is high only during an owned read, and it is never high while ack_n is high after the release edge.
- R8: The LED register changes only on the edge that accepts an owned write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 1 | Asynchronous active-low request from the initiator |
| cmd | input | 1 | Direction: 0 read, 1 write |
| ads | input | ADDR_W | Bus address |
| data_in | input | DATA_W | Data lines as seen by the target |
| data_out | output | DATA_W | Read data presented to the bus |
| data_oe | output | 1 | Output enable for data_out |
| ack_n | output | 1 | Active-low acknowledge |
| button | input | 1 | Raw push-button level, 1 when pressed |
| led | output | 1 | LED drive register |

## Verification
The embedded assertions check properties that must hold on every cycle: the upper read bits are zero whenever the bus is driven, the acknowledge only falls while the request is still low, the data bus is already released when the acknowledge rises, and the LED changes only on the edge that accepts a write. The bench's scenarios are the only place to show the things that depend on the full sequence of a transaction. These are the exact number of cycles from request to acknowledge, the value read for each button level, the LED value after writes with different upper bits, and the silence of the target on foreign addresses and wrong directions.

// File: rtl/mmio_button_led_target.sv
module mmio_button_led_target #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int BTN_ADDR  = 4,
  parameter int LED_ADDR  = 5,
  parameter int ACK_DELAY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_n,
  input  logic              cmd,
  input  logic [ADDR_W-1:0] ads,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              ack_n,
  input  logic              button,
  output logic              led
);
  localparam int CW = $clog2(ACK_DELAY + 1);
  localparam logic [CW-1:0] LAST = CW'(ACK_DELAY - 1);
  localparam logic [ADDR_W-1:0] A_BTN = ADDR_W'(BTN_ADDR);
  localparam logic [ADDR_W-1:0] A_LED = ADDR_W'(LED_ADDR);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_HOLD, S_DONE, S_SKIP} st_t;

  st_t           st;
  logic [1:0]    req_ff, btn_ff;
  logic [CW-1:0] cnt;
  logic          req_s, btn_s, rd_hit, wr_hit, take;

  assign req_s  = req_ff[1];
  assign btn_s  = btn_ff[1];
  assign rd_hit = !cmd && (ads == A_BTN);
  assign wr_hit =  cmd && (ads == A_LED);
  assign take   = (st == S_IDLE) && !req_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_ff <= 2'b11;
      btn_ff <= 2'b00;
    end else begin
      req_ff <= {req_ff[0], req_n};
      btn_ff <= {btn_ff[0], button};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      ack_n    <= 1'b1;
      data_oe  <= 1'b0;
      data_out <= '0;
      led      <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (!req_s) begin
          cnt <= '0;
          if (rd_hit) begin
            data_out <= DATA_W'(btn_s);
            data_oe  <= 1'b1;
            st       <= S_WAIT;
          end else if (wr_hit) begin
            led <= data_in[0];
            st  <= S_WAIT;
          end else begin
            st <= S_SKIP;
          end
        end
        S_WAIT: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            ack_n <= 1'b0;
            st    <= S_HOLD;
          end
        end
        S_HOLD: if (req_s) begin
          data_oe <= 1'b0;
          st      <= S_DONE;
        end
        S_DONE: begin
          ack_n <= 1'b1;
          st    <= S_IDLE;
        end
        S_SKIP: if (req_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (data_out[DATA_W-1:1] == '0));

  a_r3_ack_while_req_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> !req_s);

  a_r4_release_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_n) |-> (!data_oe && $past(!data_oe)));

  a_r8_led_only_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(led) |-> $past(take && cmd));

  a_r7_oe_not_in_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP) |-> (!data_oe && ack_n));
endmodule

// File: tb/mmio_button_led_target_tb.sv
module mmio_button_led_target_tb_top;
  localparam int DLY = 2;
  logic clk = 1'b0, rst_n = 1'b0, req_n = 1'b1, cmd = 1'b0, button = 1'b0;
  logic [7:0] ads = 8'h00, data_in = 8'h00;
  logic [7:0] data_out;
  logic data_oe, ack_n, led;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mmio_button_led_target #(.ACK_DELAY(DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .cmd(cmd), .ads(ads),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .ack_n(ack_n), .button(button), .led(led));

  // behavioural reference: phase 0 idle, 1 counting, 2 acked, 3 releasing, 4 foreign
  logic [1:0] m_req = 2'b11, m_btn = 2'b00;
  int m_ph = 0, m_cnt = 0;
  logic m_ack = 1'b1, m_oe = 1'b0, m_led = 1'b0;
  logic [7:0] m_dout = 8'h00;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_req <= 2'b11; m_btn <= 2'b00; m_ph <= 0; m_cnt <= 0;
      m_ack <= 1'b1; m_oe <= 1'b0; m_led <= 1'b0; m_dout <= 8'h00;
    end else begin
      m_req <= {m_req[0], req_n};
      m_btn <= {m_btn[0], button};
      if (m_ph == 0 && !m_req[1]) begin
        m_cnt <= 0;
        if (cmd == 1'b0 && ads == 8'h04) begin
          m_dout <= {7'd0, m_btn[1]}; m_oe <= 1'b1; m_ph <= 1;
        end else if (cmd == 1'b1 && ads == 8'h05) begin
          m_led <= data_in[0]; m_ph <= 1;
        end else m_ph <= 4;
      end else if (m_ph == 1) begin
        m_cnt <= m_cnt + 1;
        if (m_cnt + 1 == DLY) begin m_ack <= 1'b0; m_ph <= 2; end
      end else if (m_ph == 2 && m_req[1]) begin
        m_oe <= 1'b0; m_ph <= 3;
      end else if (m_ph == 3) begin
        m_ack <= 1'b1; m_ph <= 0;
      end else if (m_ph == 4 && m_req[1]) m_ph <= 0;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R3/R4 ack_n per cycle", {7'd0, ack_n}, {7'd0, m_ack});
    check("R1/R7 data_oe per cycle", {7'd0, data_oe}, {7'd0, m_oe});
    check("R2/R8 led per cycle", {7'd0, led}, {7'd0, m_led});
    if (m_oe) check("R1 data_out per cycle", data_out, m_dout);
  end

  task automatic owned(input logic c, input logic [7:0] a, input logic [7:0] d,
                       output logic [7:0] rd, output int lat);
    @(negedge clk); cmd = c; ads = a; data_in = d;
    @(negedge clk); req_n = 1'b0; lat = 0;
    while (ack_n !== 1'b0 && lat < 50) begin @(negedge clk); lat++; end
    rd = data_out;
    req_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic foreign(input logic c, input logic [7:0] a, input logic [7:0] d);
    logic seen;
    @(negedge clk); cmd = c; ads = a; data_in = d;
    @(negedge clk); req_n = 1'b0; seen = 1'b0;
    repeat (10) begin @(negedge clk); if (!ack_n || data_oe) seen = 1'b1; end
    check("R5 no ack or drive on foreign txn", {7'd0, seen}, 8'h00);
    req_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #20000000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd; int lat;
    repeat (3) @(negedge clk);
    check("R6 ack_n in reset", {7'd0, ack_n}, 8'h01);
    check("R6 data_oe in reset", {7'd0, data_oe}, 8'h00);
    check("R6 led in reset", {7'd0, led}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 led after reset", {7'd0, led}, 8'h00);

    button = 1'b1; repeat (3) @(negedge clk);
    owned(1'b0, 8'h04, 8'hAA, rd, lat);
    check("R1 read pressed", rd, 8'h01);
    check("R3 request-to-ack edges", 8'(lat), 8'(3 + DLY));
    button = 1'b0; repeat (3) @(negedge clk);
    owned(1'b0, 8'h04, 8'hFF, rd, lat);
    check("R1 read released", rd, 8'h00);

    owned(1'b1, 8'h05, 8'hF5, rd, lat);
    check("R2 write bit0=1", {7'd0, led}, 8'h01);
    check("R3 write ack edges", 8'(lat), 8'(3 + DLY));
    owned(1'b1, 8'h05, 8'hFE, rd, lat);
    check("R2 write upper bits ignored", {7'd0, led}, 8'h00);
    owned(1'b1, 8'h05, 8'h01, rd, lat);
    check("R2 write back to 1", {7'd0, led}, 8'h01);

    foreign(1'b0, 8'h05, 8'h00);
    foreign(1'b1, 8'h04, 8'h00);
    foreign(1'b0, 8'h24, 8'h00);
    foreign(1'b1, 8'h31, 8'hF4);
    check("R5 led unchanged after foreign", {7'd0, led}, 8'h01);
    check("R7 bus released when idle", {7'd0, data_oe}, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule